// File: doc/BRIEF.md
# Split Address/Data Register File

This block holds sixteen 32-bit integer registers in two banks of eight. One bank holds data registers and the other holds address registers, and each is selected with a 3-bit field. The data ALU has two read ports and one write port on the data bank. The address-generation unit (AGU) has two read ports and one write port on the address bank. Because the banks do not share ports, both units can read and write in the same cycle without waiting for each other.

The AGU fetches operands with a request/ready/response handshake. A plain request returns one address register, which is the base, one cycle after it is accepted. An indexed request also takes one data register as an index. That index crosses to the address side over a narrow bridge bus, one bridge-width slice per cycle, lowest slice first. While the bridge is moving data, `aguReady` stays low and any request presented is ignored.

A data-side write raises a condition-flag update strobe in the next cycle. An address-side write never raises it.

Top module: `splitRegFile`

## Requirements
- R1: After reset every register in both banks reads zero, `aguReady` is 1, and `aguRespValid` and `flagUpd` are 0.
- R2: ALU writes change only the data bank, and AGU writes change only the address bank. A write to register n of one bank leaves register n of the other bank unchanged.
- R3: All read ports are write-first. A read of the register being written in the same cycle returns the value that will be stored.
- R4: A long ALU write (`aluWrWord`=0) replaces all 32 bits. A word ALU write (`aluWrWord`=1) replaces bits 15:0 and keeps bits 31:16.
- R5: An AGU write always replaces all 32 bits. A word AGU write (`aguWrWord`=1) stores `aguWrData[15:0]` sign-extended from bit 15.
- R6: `flagUpd` is 1 in the cycle after a cycle with `aluWrEn`=1, and 0 in every other cycle. AGU writes never set it.
- R7: A plain request (`aguIdxEn`=0) is accepted in a cycle where `aguReqValid` and `aguReady` are both 1. In the next cycle `aguRespValid`=1, `aguBase` holds the selected address register (including a write made to it in the accepting cycle), and `aguIndex`=0.
- R8: An indexed request (`aguIdxEn`=1) moves the data register over the 16-bit bridge in two transfers, bits 15:0 first and then bits 31:16. `aguReady` and `aguRespValid` are 0 for the two cycles after acceptance. In the third cycle `aguRespValid`=1, `aguBase` holds the address register as it was at acceptance, and `aguIndex` holds the full 32-bit data register.
- R9: While the bridge is busy, ALU reads and writes go ahead at full rate. A request presented while `aguReady`=0 is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aluRdSelA | input | 3 | Data register select, ALU read port A |
| aluRdSelB | input | 3 | Data register select, ALU read port B |
| aluRdDataA | output | 32 | ALU read port A data |
| aluRdDataB | output | 32 | ALU read port B data |
| aluWrEn | input | 1 | ALU write enable |
| aluWrWord | input | 1 | 1: word write of bits 15:0 only |
| aluWrSel | input | 3 | Data register written |
| aluWrData | input | 32 | ALU write data |
| flagUpd | output | 1 | Condition-flag update strobe |
| aguAuxSel | input | 3 | Address register select, AGU auxiliary read |
| aguAuxData | output | 32 | AGU auxiliary read data |
| aguWrEn | input | 1 | AGU write enable |
| aguWrWord | input | 1 | 1: sign-extend bits 15:0 |
| aguWrSel | input | 3 | Address register written |
| aguWrData | input | 32 | AGU write data |
| aguReqValid | input | 1 | Operand request valid |
| aguReady | output | 1 | File can accept a request |
| aguBaseSel | input | 3 | Base address register of the request |
| aguIdxEn | input | 1 | 1: request also fetches an index |
| aguIdxSel | input | 3 | Data register used as the index |
| aguRespValid | output | 1 | Response valid (one-cycle pulse) |
| aguBase | output | 32 | Base operand of the response |
| aguIndex | output | 32 | Index operand of the response (0 for plain) |

## Verification
The assertions assume that `aguReqValid` stays low while reset is held and that all selects stay within the eight registers. They also assume the sampled request fields are stable around the clock edge. The bench drives every input a short time after the rising edge, keeps requests deasserted during reset, and uses only 3-bit selects. Some bench requests are deliberately left asserted while `aguReady` is low, to show that such requests are ignored. The bench drops them before the bridge goes idle again.

// File: rtl/srfPkg.sv
package srfPkg;
  localparam int BEAT_IDX_W = 4;

  typedef enum logic {
    BR_IDLE = 1'b0,
    BR_XFER = 1'b1
  } bridgeState_t;

  typedef struct packed {
    logic                  acceptPlain;
    logic                  acceptIdx;
    logic                  beatEn;
    logic                  lastBeat;
    logic [BEAT_IDX_W-1:0] beatIdx;
  } srfStrobes_t;
endpackage

// File: rtl/regBank.sv
module regBank #(
  parameter int W      = 32,
  parameter int DEPTH  = 8,
  parameter int NRD    = 2,
  parameter int HALF_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0]    rdSel,
  output logic [NRD-1:0][W-1:0]                rdData,
  input  logic                                 wrEn,
  input  logic                                 wrLowOnly,
  input  logic [$clog2(DEPTH)-1:0]             wrSel,
  input  logic [W-1:0]                         wrData
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] wrVal;

  // merged value: word writes keep the upper part of the old contents
  always_comb begin
    if (wrLowOnly) wrVal = {mem[wrSel][W-1:HALF_W], wrData[HALF_W-1:0]};
    else           wrVal = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrSel] <= wrVal;
    end
  end

  // write-first read ports
  for (genvar g = 0; g < NRD; g++) begin : gRd
    assign rdData[g] = (wrEn && (wrSel == rdSel[g])) ? wrVal : mem[rdSel[g]];
  end
endmodule

// File: rtl/splitRegCtrl.sv
module splitRegCtrl
  import srfPkg::*;
#(
  parameter int NBEATS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        aguReqValid,
  input  logic        aguIdxEn,
  input  logic        aluWrEn,
  output logic        aguReady,
  output logic        aguRespValid,
  output logic        flagUpd,
  output srfStrobes_t strb
);
  localparam int CW = (NBEATS > 1) ? $clog2(NBEATS) : 1;

  bridgeState_t state;
  logic [CW-1:0] beatCnt;
  logic lastBeat;

  assign aguReady = (state == BR_IDLE);
  assign lastBeat = (beatCnt == CW'(NBEATS - 1));

  always_comb begin
    strb.acceptPlain = aguReqValid && aguReady && !aguIdxEn;
    strb.acceptIdx   = aguReqValid && aguReady && aguIdxEn;
    strb.beatEn      = (state == BR_XFER);
    strb.lastBeat    = (state == BR_XFER) && lastBeat;
    strb.beatIdx     = BEAT_IDX_W'(beatCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= BR_IDLE;
      beatCnt <= '0;
    end else begin
      case (state)
        BR_IDLE: if (strb.acceptIdx) begin
          state   <= BR_XFER;
          beatCnt <= '0;
        end
        BR_XFER: if (lastBeat) begin
          state   <= BR_IDLE;
          beatCnt <= '0;
        end else begin
          beatCnt <= beatCnt + 1'b1;
        end
        default: state <= BR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aguRespValid <= 1'b0;
      flagUpd      <= 1'b0;
    end else begin
      aguRespValid <= strb.acceptPlain || strb.lastBeat;
      flagUpd      <= aluWrEn;
    end
  end
endmodule

// File: rtl/splitRegData.sv
module splitRegData
  import srfPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int REG_CNT  = 8,
  parameter int BRIDGE_W = 16,
  parameter int HALF_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  srfStrobes_t                strb,
  input  logic [$clog2(REG_CNT)-1:0] aluRdSelA,
  input  logic [$clog2(REG_CNT)-1:0] aluRdSelB,
  output logic [DATA_W-1:0]          aluRdDataA,
  output logic [DATA_W-1:0]          aluRdDataB,
  input  logic                       aluWrEn,
  input  logic                       aluWrWord,
  input  logic [$clog2(REG_CNT)-1:0] aluWrSel,
  input  logic [DATA_W-1:0]          aluWrData,
  input  logic [$clog2(REG_CNT)-1:0] aguAuxSel,
  output logic [DATA_W-1:0]          aguAuxData,
  input  logic                       aguWrEn,
  input  logic                       aguWrWord,
  input  logic [$clog2(REG_CNT)-1:0] aguWrSel,
  input  logic [DATA_W-1:0]          aguWrData,
  input  logic [$clog2(REG_CNT)-1:0] aguBaseSel,
  input  logic [$clog2(REG_CNT)-1:0] aguIdxSel,
  output logic [DATA_W-1:0]          aguBase,
  output logic [DATA_W-1:0]          aguIndex
);
  localparam int SW     = $clog2(REG_CNT);
  localparam int NBEATS = DATA_W / BRIDGE_W;
  localparam int CW     = (NBEATS > 1) ? $clog2(NBEATS) : 1;

  // data bank: port 0/1 for the ALU, port 2 taps the bridge
  logic [2:0][SW-1:0]     dSel;
  logic [2:0][DATA_W-1:0] dRd;
  // address bank: port 0 base, port 1 auxiliary
  logic [1:0][SW-1:0]     aSel;
  logic [1:0][DATA_W-1:0] aRd;
  logic [DATA_W-1:0]      aguWrExt;
  logic [SW-1:0]          idxSelHold;

  logic [NBEATS-1:0][BRIDGE_W-1:0] tapSlices;
  logic [NBEATS-1:0][BRIDGE_W-1:0] idxAcc;
  logic [NBEATS-1:0][BRIDGE_W-1:0] idxMerged;
  logic [BRIDGE_W-1:0]             bridgeBus;
  logic [CW-1:0]                   beatSel;

  assign dSel = {idxSelHold, aluRdSelB, aluRdSelA};
  assign aSel = {aguAuxSel, aguBaseSel};
  assign aluRdDataA = dRd[0];
  assign aluRdDataB = dRd[1];
  assign aguAuxData = aRd[1];

  always_comb begin
    if (aguWrWord) aguWrExt = {{(DATA_W-HALF_W){aguWrData[HALF_W-1]}}, aguWrData[HALF_W-1:0]};
    else           aguWrExt = aguWrData;
  end

  regBank #(.W(DATA_W), .DEPTH(REG_CNT), .NRD(3), .HALF_W(HALF_W)) uDataBank (
    .clk(clk), .rstN(rstN), .rdSel(dSel), .rdData(dRd),
    .wrEn(aluWrEn), .wrLowOnly(aluWrWord), .wrSel(aluWrSel), .wrData(aluWrData)
  );

  regBank #(.W(DATA_W), .DEPTH(REG_CNT), .NRD(2), .HALF_W(HALF_W)) uAddrBank (
    .clk(clk), .rstN(rstN), .rdSel(aSel), .rdData(aRd),
    .wrEn(aguWrEn), .wrLowOnly(1'b0), .wrSel(aguWrSel), .wrData(aguWrExt)
  );

  // bridge: one slice of the held index register per transfer cycle
  assign tapSlices = dRd[2];
  assign beatSel   = strb.beatIdx[CW-1:0];
  assign bridgeBus = tapSlices[beatSel];

  always_comb begin
    idxMerged          = idxAcc;
    idxMerged[beatSel] = bridgeBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxSelHold <= '0;
      idxAcc     <= '0;
      aguBase    <= '0;
      aguIndex   <= '0;
    end else begin
      if (strb.acceptIdx) idxSelHold <= aguIdxSel;
      if (strb.acceptPlain || strb.acceptIdx) aguBase <= aRd[0];
      if (strb.acceptPlain) aguIndex <= '0;
      if (strb.beatEn) idxAcc <= idxMerged;
      if (strb.lastBeat) aguIndex <= idxMerged;
    end
  end
endmodule

// File: rtl/splitRegFile.sv
module splitRegFile
  import srfPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int REG_CNT  = 8,
  parameter int BRIDGE_W = 16,
  parameter int HALF_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(REG_CNT)-1:0] aluRdSelA,
  input  logic [$clog2(REG_CNT)-1:0] aluRdSelB,
  output logic [DATA_W-1:0]          aluRdDataA,
  output logic [DATA_W-1:0]          aluRdDataB,
  input  logic                       aluWrEn,
  input  logic                       aluWrWord,
  input  logic [$clog2(REG_CNT)-1:0] aluWrSel,
  input  logic [DATA_W-1:0]          aluWrData,
  output logic                       flagUpd,
  input  logic [$clog2(REG_CNT)-1:0] aguAuxSel,
  output logic [DATA_W-1:0]          aguAuxData,
  input  logic                       aguWrEn,
  input  logic                       aguWrWord,
  input  logic [$clog2(REG_CNT)-1:0] aguWrSel,
  input  logic [DATA_W-1:0]          aguWrData,
  input  logic                       aguReqValid,
  output logic                       aguReady,
  input  logic [$clog2(REG_CNT)-1:0] aguBaseSel,
  input  logic                       aguIdxEn,
  input  logic [$clog2(REG_CNT)-1:0] aguIdxSel,
  output logic                       aguRespValid,
  output logic [DATA_W-1:0]          aguBase,
  output logic [DATA_W-1:0]          aguIndex
);
  localparam int NBEATS = DATA_W / BRIDGE_W;

  srfStrobes_t strb;

  splitRegCtrl #(.NBEATS(NBEATS)) uCtrl (
    .clk(clk), .rstN(rstN), .aguReqValid(aguReqValid), .aguIdxEn(aguIdxEn),
    .aluWrEn(aluWrEn), .aguReady(aguReady), .aguRespValid(aguRespValid),
    .flagUpd(flagUpd), .strb(strb)
  );

  splitRegData #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .BRIDGE_W(BRIDGE_W), .HALF_W(HALF_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .aluRdSelA(aluRdSelA), .aluRdSelB(aluRdSelB), .aluRdDataA(aluRdDataA), .aluRdDataB(aluRdDataB),
    .aluWrEn(aluWrEn), .aluWrWord(aluWrWord), .aluWrSel(aluWrSel), .aluWrData(aluWrData),
    .aguAuxSel(aguAuxSel), .aguAuxData(aguAuxData),
    .aguWrEn(aguWrEn), .aguWrWord(aguWrWord), .aguWrSel(aguWrSel), .aguWrData(aguWrData),
    .aguBaseSel(aguBaseSel), .aguIdxSel(aguIdxSel), .aguBase(aguBase), .aguIndex(aguIndex)
  );
endmodule

// File: rtl/splitRegFileChk.sv
module splitRegFileChk #(
  parameter int DATA_W   = 32,
  parameter int REG_CNT  = 8,
  parameter int BRIDGE_W = 16,
  parameter int HALF_W   = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [$clog2(REG_CNT)-1:0] aluRdSelA,
  input logic [DATA_W-1:0]          aluRdDataA,
  input logic                       aluWrEn,
  input logic                       aluWrWord,
  input logic [$clog2(REG_CNT)-1:0] aluWrSel,
  input logic [DATA_W-1:0]          aluWrData,
  input logic                       flagUpd,
  input logic [$clog2(REG_CNT)-1:0] aguAuxSel,
  input logic [DATA_W-1:0]          aguAuxData,
  input logic                       aguWrEn,
  input logic                       aguWrWord,
  input logic [$clog2(REG_CNT)-1:0] aguWrSel,
  input logic [DATA_W-1:0]          aguWrData,
  input logic                       aguReqValid,
  input logic                       aguReady,
  input logic                       aguIdxEn,
  input logic                       aguRespValid,
  input logic [DATA_W-1:0]          aguIndex
);
  localparam int NBEATS = DATA_W / BRIDGE_W;

  logic plainAcc, idxAcc;
  logic [7:0] sinceIdx;

  assign plainAcc = aguReqValid && aguReady && !aguIdxEn;
  assign idxAcc   = aguReqValid && aguReady && aguIdxEn;

  // cycle count since an indexed acceptance, so the window follows NBEATS
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sinceIdx <= '0;
    else if (idxAcc)                    sinceIdx <= 8'd1;
    else if (sinceIdx == 8'(NBEATS + 1)) sinceIdx <= '0;
    else if (sinceIdx != '0)            sinceIdx <= sinceIdx + 8'd1;
  end

  AST_IDX_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceIdx != '0 && sinceIdx <= 8'(NBEATS)) |-> (!aguReady && !aguRespValid)); // R8
  AST_IDX_RESP: assert property (@(posedge clk) disable iff (!rstN)
    (sinceIdx == 8'(NBEATS + 1)) |-> aguRespValid); // R8
  AST_PLAIN_RESP: assert property (@(posedge clk) disable iff (!rstN)
    plainAcc |=> (aguRespValid && aguIndex == '0)); // R7
  AST_FLAG_AFTER_ALU: assert property (@(posedge clk) disable iff (!rstN)
    aluWrEn |=> flagUpd); // R6
  AST_FLAG_ONLY_ALU: assert property (@(posedge clk) disable iff (!rstN)
    flagUpd |-> $past(aluWrEn)); // R6
  AST_ALU_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (aluWrEn && !aluWrWord && aluWrSel == aluRdSelA) |-> (aluRdDataA == aluWrData)); // R3
  AST_ADDR_SEXT: assert property (@(posedge clk) disable iff (!rstN)
    (aguWrEn && aguWrWord && aguWrSel == aguAuxSel) |->
      (aguAuxData == {{(DATA_W-HALF_W){aguWrData[HALF_W-1]}}, aguWrData[HALF_W-1:0]})); // R5
endmodule

bind splitRegFile splitRegFileChk #(
  .DATA_W(DATA_W), .REG_CNT(REG_CNT), .BRIDGE_W(BRIDGE_W), .HALF_W(HALF_W)
) uChk (
  .clk(clk), .rstN(rstN), .aluRdSelA(aluRdSelA), .aluRdDataA(aluRdDataA),
  .aluWrEn(aluWrEn), .aluWrWord(aluWrWord), .aluWrSel(aluWrSel), .aluWrData(aluWrData),
  .flagUpd(flagUpd), .aguAuxSel(aguAuxSel), .aguAuxData(aguAuxData),
  .aguWrEn(aguWrEn), .aguWrWord(aguWrWord), .aguWrSel(aguWrSel), .aguWrData(aguWrData),
  .aguReqValid(aguReqValid), .aguReady(aguReady), .aguIdxEn(aguIdxEn),
  .aguRespValid(aguRespValid), .aguIndex(aguIndex)
);

// File: tb/tb_splitRegFile.sv
module tb_splitRegFile;
  logic clk = 1'b0;
  logic rstN;
  logic [2:0]  aluRdSelA, aluRdSelB, aluWrSel, aguAuxSel, aguWrSel, aguBaseSel, aguIdxSel;
  logic [31:0] aluRdDataA, aluRdDataB, aluWrData, aguAuxData, aguWrData, aguBase, aguIndex;
  logic aluWrEn, aluWrWord, flagUpd, aguWrEn, aguWrWord, aguReqValid, aguReady, aguIdxEn, aguRespValid;

  int total = 0;
  int bad   = 0;
  logic [31:0] dM [8];
  logic [31:0] aM [8];

  always #10 clk = ~clk;

  splitRegFile dut (
    .clk(clk), .rstN(rstN),
    .aluRdSelA(aluRdSelA), .aluRdSelB(aluRdSelB), .aluRdDataA(aluRdDataA), .aluRdDataB(aluRdDataB),
    .aluWrEn(aluWrEn), .aluWrWord(aluWrWord), .aluWrSel(aluWrSel), .aluWrData(aluWrData),
    .flagUpd(flagUpd), .aguAuxSel(aguAuxSel), .aguAuxData(aguAuxData),
    .aguWrEn(aguWrEn), .aguWrWord(aguWrWord), .aguWrSel(aguWrSel), .aguWrData(aguWrData),
    .aguReqValid(aguReqValid), .aguReady(aguReady), .aguBaseSel(aguBaseSel),
    .aguIdxEn(aguIdxEn), .aguIdxSel(aguIdxSel), .aguRespValid(aguRespValid),
    .aguBase(aguBase), .aguIndex(aguIndex)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    {aluWrEn, aluWrWord, aguWrEn, aguWrWord, aguReqValid, aguIdxEn} = '0;
    {aluRdSelA, aluRdSelB, aluWrSel, aguAuxSel, aguWrSel, aguBaseSel, aguIdxSel} = '0;
    aluWrData = '0;
    aguWrData = '0;
    for (int i = 0; i < 8; i++) begin dM[i] = '0; aM[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    tick();
    check("R1 ready", 32'(aguReady), 32'd1);
    check("R1 respValid", 32'(aguRespValid), 32'd0);
    check("R1 flagUpd", 32'(flagUpd), 32'd0);
    for (int i = 0; i < 8; i++) begin
      tick();
      aluRdSelA = 3'(i); aguAuxSel = 3'(i);
      #2;
      check("R1 data reg zero", aluRdDataA, 32'd0);
      check("R1 addr reg zero", aguAuxData, 32'd0);
    end

    // R3/R4/R6: long ALU writes with bypass and flag strobe
    for (int i = 0; i < 8; i++) begin
      tick();
      if (i > 0) check("R6 flag after alu write", 32'(flagUpd), 32'd1);
      aluWrEn = 1'b1; aluWrWord = 1'b0; aluWrSel = 3'(i);
      aluWrData = 32'h1357_0000 * (i + 1) + 32'h0000_2468 + 32'(i);
      aluRdSelA = 3'(i);
      #2;
      check("R3 alu bypass", aluRdDataA, aluWrData);
      dM[i] = aluWrData;
    end
    tick();
    check("R6 flag after last alu write", 32'(flagUpd), 32'd1);
    aluWrEn = 1'b0;

    // R5/R6/R2: long AGU writes, no flag strobe
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R6 no flag on agu write", 32'(flagUpd), 32'd0);
      aguWrEn = 1'b1; aguWrWord = 1'b0; aguWrSel = 3'(i);
      aguWrData = 32'hC0DE_0000 ^ (32'h0011_1111 * 32'(i));
      aguAuxSel = 3'(i);
      #2;
      check("R3 agu bypass", aguAuxData, aguWrData);
      aM[i] = aguWrData;
    end
    tick();
    check("R6 no flag after agu writes", 32'(flagUpd), 32'd0);
    aguWrEn = 1'b0;

    // R2 readback sweep over both banks
    for (int i = 0; i < 8; i++) begin
      tick();
      aluRdSelA = 3'(i); aluRdSelB = 3'(7 - i); aguAuxSel = 3'(i);
      #2;
      check("R2 data bank A", aluRdDataA, dM[i]);
      check("R2 data bank B", aluRdDataB, dM[7 - i]);
      check("R2 addr bank", aguAuxData, aM[i]);
    end

    // R4 word writes on data, R5 sign-extended word writes on address
    for (int i = 0; i < 8; i++) begin
      tick();
      aluWrEn = 1'b1; aluWrWord = 1'b1; aluWrSel = 3'(i);
      aluWrData = 32'hFFFF_0000 | 32'(16'h8000 ^ (16'h0111 * 16'(i)));
      dM[i] = {dM[i][31:16], aluWrData[15:0]};
      aguWrEn = 1'b1; aguWrWord = 1'b1; aguWrSel = 3'(i);
      aguWrData = 32'hABCD_0000 | ((i % 2 == 1) ? 32'(16'h7000 + 16'(i)) : 32'(16'h9000 + 16'(i)));
      aM[i] = sext(aguWrData[15:0]);
      aluRdSelA = 3'(i); aguAuxSel = 3'(i);
      #2;
      check("R4 word bypass keeps upper", aluRdDataA, dM[i]);
      check("R5 sign extend bypass", aguAuxData, aM[i]);
    end
    tick();
    aluWrEn = 1'b0; aguWrEn = 1'b0; aluWrWord = 1'b0; aguWrWord = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      aluRdSelA = 3'(i); aguAuxSel = 3'(i);
      #2;
      check("R4 word write stored", aluRdDataA, dM[i]);
      check("R5 sign extend stored", aguAuxData, aM[i]);
    end

    // R7 plain requests, one with a same-cycle write to the base
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R7 ready before plain", 32'(aguReady), 32'd1);
      aguReqValid = 1'b1; aguIdxEn = 1'b0; aguBaseSel = 3'(i);
      if (i == 5) begin
        aguWrEn = 1'b1; aguWrWord = 1'b0; aguWrSel = 3'(i); aguWrData = 32'h5A5A_0F0F;
        aM[i] = aguWrData;
      end
      tick();
      aguReqValid = 1'b0; aguWrEn = 1'b0;
      #2;
      check("R7 plain respValid", 32'(aguRespValid), 32'd1);
      check("R7 plain base", aguBase, aM[i]);
      check("R7 plain index zero", aguIndex, 32'd0);
    end

    // R8/R9 indexed requests across the bridge
    for (int i = 0; i < 8; i++) begin
      tick();
      check("R8 ready before indexed", 32'(aguReady), 32'd1);
      aguReqValid = 1'b1; aguIdxEn = 1'b1;
      aguBaseSel = 3'((i + 3) % 8); aguIdxSel = 3'(i);
      tick();
      // a different request held during the bridge must be ignored
      aguIdxEn = 1'b0; aguBaseSel = 3'((i + 1) % 8); aguIdxSel = 3'((i + 2) % 8);
      aguWrEn = 1'b1; aguWrWord = 1'b0; aguWrSel = 3'((i + 3) % 8); aguWrData = 32'hDEAD_0000 + 32'(i);
      aluWrEn = 1'b1; aluWrWord = 1'b0; aluWrSel = 3'((i + 4) % 8);
      aluWrData = 32'h0F00_0000 + 32'(i * 7);
      aluRdSelB = 3'((i + 4) % 8);
      #2;
      check("R8 ready low beat0", 32'(aguReady), 32'd0);
      check("R8 no resp beat0", 32'(aguRespValid), 32'd0);
      check("R9 alu bypass during bridge", aluRdDataB, aluWrData);
      tick();
      dM[(i + 4) % 8] = aluWrData;
      aluWrEn = 1'b0; aguWrEn = 1'b0;
      #2;
      check("R8 ready low beat1", 32'(aguReady), 32'd0);
      check("R8 no resp beat1", 32'(aguRespValid), 32'd0);
      tick();
      aguReqValid = 1'b0;
      #2;
      check("R8 indexed respValid", 32'(aguRespValid), 32'd1);
      check("R8 indexed base", aguBase, aM[(i + 3) % 8]);
      check("R8 indexed index", aguIndex, dM[i]);
      check("R8 ready after bridge", 32'(aguReady), 32'd1);
      aM[(i + 3) % 8] = 32'hDEAD_0000 + 32'(i);
      tick();
      check("R9 held request not accepted", 32'(aguRespValid), 32'd0);
      check("R9 alu write during bridge kept", 32'(dut.aluRdDataB), dM[(i + 4) % 8]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule